// File: doc/BRIEF.md
# Split-Transaction Queue-Head State Engine

This block follows one asynchronous queue head of a high-speed host controller while that queue head reaches a full- or low-speed device through a transaction translator. Each bus attempt reports three things. The first is the queue head's PID code. The second is a response code. The third is a flag that says whether the current micro-frame still has time for another transaction. From these the engine updates four things: the split phase (start-split or complete-split), a small error counter, a sticky transaction-error bit and a halt bit.

For every response it accepts, the engine raises exactly one outcome strobe for one cycle. The four strobes are:
- move on to the next queue head;
- retry the complete-split at once;
- pin this queue head so that it runs first in the next micro-frame;
- retire the transfer descriptor.

The scheduler acts on the strobe. Software prepares the queue head with a load pulse, which also clears a halt. While the queue head is halted, the engine ignores responses.

Top module: `split_qh_engine`

## Requirements
- R1: After reset the engine is in start-split with the error counter at its maximum (3), halt and transaction-error clear and no strobe. A `sw_load` pulse sets start-split, copies `sw_cerr` into the counter, clears halt and transaction-error, raises no strobe, and takes priority over a response in the same cycle.
- R2: The PID encoding is OUT=00, IN=01, SETUP=10. The response encoding is ACK=000, NAK=001, NYET=010, STALL=011 and transaction error (timeout, bad response or CRC failure)=100; values 101 to 111 count as transaction error. Each accepted response gives exactly one strobe in the next cycle, and a cycle without a response gives none.
- R3: An ACK to a start-split moves the engine to complete-split and signals next. The counter reloads to 3 for IN or OUT and stays unchanged for SETUP.
- R4: A NAK to a start-split changes nothing and signals next.
- R5: A transaction error, NYET or STALL to a start-split stays in start-split, decrements the counter, sets transaction-error and signals next.
- R6: A NYET to a complete-split stays in complete-split and signals next. The counter reloads to 3 for IN or OUT and stays unchanged for SETUP.
- R7: A transaction error to a complete-split stays in complete-split, decrements the counter and sets transaction-error. It signals retry when the time flag is 1 and pin when it is 0.
- R8: An ACK to a complete-split returns the engine to start-split, keeps the counter and signals next.
- R9: A NAK to a complete-split returns the engine to start-split and signals next. For SETUP it also sets transaction-error and decrements the counter; for IN or OUT the counter and the error bit stay unchanged.
- R10: A STALL to a complete-split sets halt, keeps the split phase and counter, and signals retire.
- R11: A decrement from 1 to 0 sets halt and signals next instead of retry or pin. When the counter is already 0, a decrement leaves it at 0 and does not halt.
- R12: While halt is set, responses change no state and raise no strobe, until `sw_load` clears halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_load | input | 1 | Software initialisation pulse |
| sw_cerr | input | CERR_W | Counter value copied on `sw_load` |
| rsp_valid | input | 1 | A response is present this cycle |
| rsp_pid | input | 2 | PID code of the queue head |
| rsp_code | input | 3 | Response code |
| uframe_time_ok | input | 1 | Time remains in the micro-frame for a retry |
| split_cs | output | 1 | 1 = complete-split phase, 0 = start-split |
| cerr | output | CERR_W | Error counter |
| halted | output | 1 | Halt status bit |
| xact_err | output | 1 | Sticky transaction-error status bit |
| go_next | output | 1 | Strobe: proceed to the next queue head |
| go_retry | output | 1 | Strobe: retry the complete-split immediately |
| go_pin | output | 1 | Strobe: start the next micro-frame with this queue head |
| go_retire | output | 1 | Strobe: retire the transfer descriptor |

## Verification
The hardest case to reach is a counter that hits zero during a complete-split transaction error while time still remains. Retry must then give way to next, together with halt. Getting there takes a load with a small count, an ACK to the start-split to enter complete-split, and then repeated errors with the time flag held at 1, so that each step shows as retry until the last one. A SETUP queue head has to be driven the same way: its counter is never refreshed, which is the only way a NAK to a complete-split can drain the counter to halt.

// File: rtl/split_qh_pkg.sv
package split_qh_pkg;

   localparam logic [1:0] PID_OUT   = 2'b00;
   localparam logic [1:0] PID_IN    = 2'b01;
   localparam logic [1:0] PID_SETUP = 2'b10;

   localparam logic [2:0] RSP_ACK   = 3'd0;
   localparam logic [2:0] RSP_NAK   = 3'd1;
   localparam logic [2:0] RSP_NYET  = 3'd2;
   localparam logic [2:0] RSP_STALL = 3'd3;
   localparam logic [2:0] RSP_XERR  = 3'd4;

   localparam int NUM_OUTCOMES = 4;

   typedef enum logic [1:0] {
      CE_KEEP   = 2'd0,
      CE_RELOAD = 2'd1,
      CE_DEC    = 2'd2
   } cerr_op_e;

   // bit position in the strobe vector is value - 1
   typedef enum logic [2:0] {
      OC_NONE   = 3'd0,
      OC_NEXT   = 3'd1,
      OC_RETRY  = 3'd2,
      OC_PIN    = 3'd3,
      OC_RETIRE = 3'd4
   } outcome_e;

endpackage

// File: rtl/split_qh_cerr.sv
module split_qh_cerr
   import split_qh_pkg::*;
#(
   parameter int CERR_W = 2
) (
   input  logic [CERR_W-1:0] cerr_q,
   input  cerr_op_e          op,
   output logic [CERR_W-1:0] cerr_d,
   output logic              at_one
);

   localparam logic [CERR_W-1:0] CERR_MAX = {CERR_W{1'b1}};
   localparam logic [CERR_W-1:0] CERR_ONE = CERR_W'(1);

   assign at_one = (cerr_q == CERR_ONE);

   always_comb begin
      unique case (op)
         CE_RELOAD: cerr_d = CERR_MAX;
         CE_DEC:    cerr_d = (cerr_q == '0) ? '0 : cerr_q - CERR_ONE;
         default:   cerr_d = cerr_q;
      endcase
   end

endmodule

// File: rtl/split_qh_decide.sv
module split_qh_decide
   import split_qh_pkg::*;
(
   input  logic       cs_q,
   input  logic [1:0] pid,
   input  logic [2:0] code,
   input  logic       time_ok,
   input  logic       cerr_at_one,
   output logic       cs_d,
   output cerr_op_e   cerr_op,
   output logic       set_xerr,
   output logic       set_halt,
   output outcome_e   outcome
);

   logic is_setup;
   assign is_setup = (pid == PID_SETUP);

   always_comb begin
      cs_d     = cs_q;
      cerr_op  = CE_KEEP;
      set_xerr = 1'b0;
      set_halt = 1'b0;
      outcome  = OC_NEXT;
      if (!cs_q) begin
         unique case (code)
            RSP_ACK: begin
               cs_d    = 1'b1;
               cerr_op = is_setup ? CE_KEEP : CE_RELOAD;
            end
            RSP_NAK: ;
            default: begin
               cerr_op  = CE_DEC;
               set_xerr = 1'b1;
            end
         endcase
      end else begin
         unique case (code)
            RSP_ACK:  cs_d = 1'b0;
            RSP_NYET: cerr_op = is_setup ? CE_KEEP : CE_RELOAD;
            RSP_NAK: begin
               cs_d = 1'b0;
               if (is_setup) begin
                  cerr_op  = CE_DEC;
                  set_xerr = 1'b1;
               end
            end
            RSP_STALL: begin
               set_halt = 1'b1;
               outcome  = OC_RETIRE;
            end
            default: begin
               cerr_op  = CE_DEC;
               set_xerr = 1'b1;
               outcome  = time_ok ? OC_RETRY : OC_PIN;
            end
         endcase
      end
      if (cerr_op == CE_DEC && cerr_at_one) begin
         set_halt = 1'b1;
         if (outcome == OC_RETRY || outcome == OC_PIN) outcome = OC_NEXT;
      end
   end

endmodule

// File: rtl/split_qh_engine.sv
module split_qh_engine
   import split_qh_pkg::*;
#(
   parameter int CERR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_load,
   input  logic [CERR_W-1:0] sw_cerr,
   input  logic              rsp_valid,
   input  logic [1:0]        rsp_pid,
   input  logic [2:0]        rsp_code,
   input  logic              uframe_time_ok,
   output logic              split_cs,
   output logic [CERR_W-1:0] cerr,
   output logic              halted,
   output logic              xact_err,
   output logic              go_next,
   output logic              go_retry,
   output logic              go_pin,
   output logic              go_retire
);

   localparam logic [CERR_W-1:0] CERR_MAX = {CERR_W{1'b1}};

   if (CERR_W < 2 || CERR_W > 4) begin : g_bad_cerr_w
      $error("split_qh_engine: CERR_W must lie in 2..4");
   end

   logic                    cs_q, halt_q, xerr_q, accept;
   logic [CERR_W-1:0]       cerr_q, cerr_d;
   logic                    cs_d, set_xerr, set_halt, at_one;
   cerr_op_e                cerr_op;
   outcome_e                outcome;
   logic [NUM_OUTCOMES-1:0] oc_oh, oc_q;

   assign accept = rsp_valid && !halt_q && !sw_load;

   split_qh_decide u_decide (
      .cs_q        (cs_q),
      .pid         (rsp_pid),
      .code        (rsp_code),
      .time_ok     (uframe_time_ok),
      .cerr_at_one (at_one),
      .cs_d        (cs_d),
      .cerr_op     (cerr_op),
      .set_xerr    (set_xerr),
      .set_halt    (set_halt),
      .outcome     (outcome)
   );

   split_qh_cerr #(.CERR_W(CERR_W)) u_cerr (
      .cerr_q (cerr_q),
      .op     (cerr_op),
      .cerr_d (cerr_d),
      .at_one (at_one)
   );

   for (genvar i = 0; i < NUM_OUTCOMES; i++) begin : g_oc
      assign oc_oh[i] = (outcome == outcome_e'(i + 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q   <= 1'b0;
         cerr_q <= CERR_MAX;
         halt_q <= 1'b0;
         xerr_q <= 1'b0;
         oc_q   <= '0;
      end else begin
         oc_q <= accept ? oc_oh : '0;
         if (sw_load) begin
            cs_q   <= 1'b0;
            cerr_q <= sw_cerr;
            halt_q <= 1'b0;
            xerr_q <= 1'b0;
         end else if (accept) begin
            cs_q   <= cs_d;
            cerr_q <= cerr_d;
            halt_q <= set_halt;
            xerr_q <= xerr_q | set_xerr;
         end
      end
   end

   assign split_cs  = cs_q;
   assign cerr      = cerr_q;
   assign halted    = halt_q;
   assign xact_err  = xerr_q;
   assign go_next   = oc_q[0];
   assign go_retry  = oc_q[1];
   assign go_pin    = oc_q[2];
   assign go_retire = oc_q[3];

   // R2
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> $countones({go_next, go_retry, go_pin, go_retire}) == 1);

   // R2
   no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> {go_next, go_retry, go_pin, go_retire} == 4'b0000);

   // R3
   ss_ack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cs_q && rsp_code == RSP_ACK && rsp_pid != PID_SETUP)
      |=> (cerr == CERR_MAX && split_cs));

   // R7
   pin_needs_no_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cs_q && rsp_code == RSP_XERR && !at_one)
      |=> (go_pin == !$past(uframe_time_ok) && go_retry == $past(uframe_time_ok)));

   // R10
   stall_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cs_q && rsp_code == RSP_STALL) |=> (halted && go_retire && split_cs));

   // R12
   halted_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !sw_load) |=> ($stable(cerr) && $stable(split_cs) && $stable(xact_err) && halted));

endmodule

// File: tb/split_qh_engine_tb_top.sv
module split_qh_engine_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw_load = 1'b0;
   logic [1:0] sw_cerr = 2'd0;
   logic       rsp_valid = 1'b0;
   logic [1:0] rsp_pid = 2'd0;
   logic [2:0] rsp_code = 3'd0;
   logic       uframe_time_ok = 1'b1;
   logic       split_cs, halted, xact_err, go_next, go_retry, go_pin, go_retire;
   logic [1:0] cerr;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   split_qh_engine #(.CERR_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sw_load(sw_load), .sw_cerr(sw_cerr),
      .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_code(rsp_code),
      .uframe_time_ok(uframe_time_ok), .split_cs(split_cs), .cerr(cerr),
      .halted(halted), .xact_err(xact_err), .go_next(go_next),
      .go_retry(go_retry), .go_pin(go_pin), .go_retire(go_retire)
   );

   // row: {pid, code, time_ok, exp cs, exp cerr, exp halt, exp xerr, exp {retire,pin,retry,next}}
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      15'b00_001_1_0_11_0_0_0001,  // R4 start-split NAK
      15'b00_100_1_0_10_0_1_0001,  // R5 start-split error
      15'b00_000_1_1_11_0_1_0001,  // R3 start-split ACK, OUT reload
      15'b00_010_1_1_11_0_1_0001,  // R6 NYET, OUT reload
      15'b00_100_1_1_10_0_1_0010,  // R7 error, time left: retry
      15'b00_100_0_1_01_0_1_0100,  // R7 error, no time: pin
      15'b00_000_1_0_01_0_1_0001,  // R8 complete-split ACK
      15'b00_000_1_1_11_0_1_0001,  // R3 start-split ACK
      15'b00_011_1_1_11_1_1_1000,  // R10 STALL
      15'b00_000_1_1_11_1_1_0000   // R12 halted: ignored
   };

   function automatic string row_req(int i);
      case (i)
         0: return "R4";
         1: return "R5";
         2: return "R3";
         3: return "R6";
         4: return "R7";
         5: return "R7";
         6: return "R8";
         7: return "R3";
         8: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(string req, logic ecs, logic [1:0] ecerr, logic eh, logic ex,
                        logic [3:0] eoc);
      logic [9:0] act, exp;
      act = {split_cs, cerr, halted, xact_err, go_retire, go_pin, go_retry, go_next};
      exp = {ecs, ecerr, eh, ex, eoc};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got cs/cerr/halt/xerr/oc=%b expected %b", req, act, exp);
      end
   endtask

   task automatic respond(logic [1:0] pid, logic [2:0] code, logic t);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_pid = pid; rsp_code = code; uframe_time_ok = t;
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic load(logic [1:0] v);
      @(negedge clk);
      sw_load = 1'b1; sw_cerr = v;
      @(posedge clk);
      @(negedge clk);
      sw_load = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1", 1'b0, 2'd3, 1'b0, 1'b0, 4'b0000);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         respond(VEC[i][14:13], VEC[i][12:10], VEC[i][9]);
         check(row_req(i), VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3:0]);
      end
      // R12 R1 load clears halt, copies counter
      load(2'd1);
      check("R12", 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000);
      // R3 SETUP keeps counter
      respond(2'b10, 3'd0, 1'b1);
      check("R3", 1'b1, 2'd1, 1'b0, 1'b0, 4'b0001);
      // R6 SETUP NYET keeps counter
      respond(2'b10, 3'd2, 1'b1);
      check("R6", 1'b1, 2'd1, 1'b0, 1'b0, 4'b0001);
      // R9 R11 SETUP NAK: error, drains to zero, halts
      respond(2'b10, 3'd1, 1'b1);
      check("R9", 1'b0, 2'd0, 1'b1, 1'b1, 4'b0001);
      // R3 IN reload
      load(2'd1);
      respond(2'b01, 3'd0, 1'b1);
      check("R3", 1'b1, 2'd3, 1'b0, 1'b0, 4'b0001);
      // R9 IN NAK: back to start-split, nothing else
      respond(2'b01, 3'd1, 1'b1);
      check("R9", 1'b0, 2'd3, 1'b0, 1'b0, 4'b0001);
      // R11 errors with time left: retry, retry, then halt with next
      respond(2'b01, 3'd0, 1'b1);
      respond(2'b01, 3'd4, 1'b1);
      check("R7", 1'b1, 2'd2, 1'b0, 1'b1, 4'b0010);
      respond(2'b01, 3'd4, 1'b1);
      check("R7", 1'b1, 2'd1, 1'b0, 1'b1, 4'b0010);
      respond(2'b01, 3'd4, 1'b1);
      check("R11", 1'b1, 2'd0, 1'b1, 1'b1, 4'b0001);
      // R11 counter at zero: no decrement, no halt
      load(2'd0);
      respond(2'b00, 3'd4, 1'b1);
      check("R11", 1'b0, 2'd0, 1'b0, 1'b1, 4'b0001);
      // R5 unused code and STALL on start-split act as errors
      load(2'd3);
      respond(2'b00, 3'd7, 1'b1);
      check("R5", 1'b0, 2'd2, 1'b0, 1'b1, 4'b0001);
      respond(2'b00, 3'd3, 1'b1);
      check("R5", 1'b0, 2'd1, 1'b0, 1'b1, 4'b0001);
      // R2 idle cycle: no strobe
      @(negedge clk);
      check("R2", 1'b0, 2'd1, 1'b0, 1'b1, 4'b0000);
      // R1 load wins over a simultaneous response
      @(negedge clk);
      sw_load = 1'b1; sw_cerr = 2'd2;
      rsp_valid = 1'b1; rsp_pid = 2'b00; rsp_code = 3'd0;
      @(posedge clk);
      @(negedge clk);
      sw_load = 1'b0; rsp_valid = 1'b0;
      check("R1", 1'b0, 2'd2, 1'b0, 1'b0, 4'b0000);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule